// File: doc/BRIEF.md
# NAND Sequential Cache Read Engine

This engine sits on the host side of a NAND device and streams a run of consecutive pages to its host. A request gives a starting row address and a page count. The engine opens the run with a normal page read. It then keeps issuing the sequential cache command, so that the array loads page N+1 into the data register while page N is clocked out of the cache register. The run is closed with the final-cache command, which moves the last loaded page into the cache register without starting another array load.

Every page is read from column 0 for a fixed number of bytes, set by a parameter. Bytes reach the host as a one-cycle strobe, and a flag marks the last byte of each page.

Running from one erase block into the next needs no special handling, because the row address simply increments. A die boundary is different. A cache command may never load a row in another die, so the engine closes the current run with the final-cache command. It then reopens a fresh run at the first row of the next die and carries on until the requested count is delivered.

The pin cycles are kept simple:

- Each command or address byte is a two-clock write strobe.
- Each data byte is a two-clock read strobe.
- After every array command the engine waits a fixed settle time, then waits for the ready/busy pin to read high.
- A cache command is sent as soon as the device reports ready. This is true even when the array is still loading, because the device accepts it in that state.

Top module: `nand_cache_stream`

## Requirements
- R1: After reset: cle=0, ale=0, we_n=1, re_n=1, dq_oe=0, busy=0, rd_valid=0.
- R2: A run opens with command 00h, two column address bytes of 00h, three row address bytes (row bits 7:0, then 15:8, then 23:16), and command 30h. Commands assert cle and address bytes assert ale.
- R3: Each write strobe holds we_n low for one clock and then high for one clock, with dq_o, cle and ale unchanged across both clocks. Each read strobe holds re_n low for one clock, captures dq_i at the end of that clock, and then holds re_n high for one clock. we_n and re_n are never low together.
- R4: After 30h, 31h or 3Fh, the engine waits T_WB clocks and then waits until rb_n is high. While rb_n is low, no strobe is driven.
- R5: A run of L pages inside one die with L≥2 issues exactly L-1 commands of 31h and then one 3Fh. A run with L=1 issues no cache command and reads the page straight after 30h.
- R6: A block boundary inside a die does not break the run: 31h keeps being issued across it.
- R7: 31h is never issued when the next row lies in another die (a die holds 2^DIE_ROW_BITS rows). The run closes with 3Fh, or with a direct read when L=1, and a new 00h–30h run opens at the next row.
- R8: Bytes reach the host in ascending row order, PAGE_BYTES per page, starting at column 0. rd_last is high only on the last byte of each page.
- R9: busy is high from an accepted start until the last byte has been delivered. A start pulse while busy, or one with page_count=0, is ignored.
- R10: A 31h is issued as soon as rb_n is high, even while the array is still loading the page requested by the previous 31h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| start_row | input | 24 | First row of the request |
| page_count | input | CNT_W | Number of pages to stream |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | Data byte strobe |
| rd_data | output | 8 | Data byte |
| rd_last | output | 1 | Last byte of a page |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_o | output | 8 | Byte driven to the device |
| dq_oe | output | 1 | Output enable for dq_o |
| dq_i | input | 8 | Byte from the device |
| rb_n | input | 1 | Ready/busy, low while busy |

## Verification
Two conditions can fall on the same page: the page count running out, and the die's last row. Both ask for the final-cache command. The bench provokes this with a request whose last page is the final row of a die. It then checks that exactly one 3Fh closes the trace and that no new 00h–30h run follows it. The bench also covers the other collisions: a run that starts on the last row of a die, which gives a one-page run with no cache command, and a 31h issued while the modelled array is still loading. In each case the full command trace and the byte stream are compared against the values the bench computes.

// File: rtl/nand_cache_stream.sv
module nand_cache_stream #(
  parameter int PAGE_BYTES   = 2048,
  parameter int DIE_ROW_BITS = 18,
  parameter int CNT_W        = 16,
  parameter int T_WB         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      start_row,
  input  logic [CNT_W-1:0] page_count,
  output logic             busy,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_last,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  input  logic [7:0]       dq_i,
  input  logic             rb_n
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int WB_W  = $clog2(T_WB + 1);
  localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_DEC, S_READ} st_t;
  typedef enum logic [1:0] {K_OPEN, K_CACHE, K_LAST, K_DIRECT} kind_t;

  st_t              st;
  kind_t            kind;
  logic             ph, fresh, cmd_cyc;
  logic [2:0]       idx;
  logic [23:0]      row;
  logic [CNT_W-1:0] rem;
  logic [COL_W-1:0] col;
  logic [WB_W-1:0]  wcnt;
  logic [7:0]       tx;

  wire can31    = (rem >= CNT_W'(2)) && !(&row[DIE_ROW_BITS-1:0]);
  wire [2:0] last_idx = (kind == K_OPEN) ? 3'd6 : 3'd0;

  always_comb begin
    tx = 8'h00;
    cmd_cyc = 1'b1;
    case (kind)
      K_CACHE: tx = 8'h31;
      K_LAST:  tx = 8'h3F;
      default: begin
        cmd_cyc = (idx == 3'd0) || (idx == 3'd6);
        case (idx)
          3'd3:    tx = row[7:0];
          3'd4:    tx = row[15:8];
          3'd5:    tx = row[23:16];
          3'd6:    tx = 8'h30;
          default: tx = 8'h00;
        endcase
      end
    endcase
  end

  assign busy  = (st != S_IDLE);
  assign dq_oe = (st == S_SEND);
  assign dq_o  = tx;
  assign cle   = (st == S_SEND) && cmd_cyc;
  assign ale   = (st == S_SEND) && !cmd_cyc;
  assign we_n  = !((st == S_SEND) && !ph);
  assign re_n  = !((st == S_READ) && !ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_OPEN; ph <= 1'b0; idx <= 3'd0; fresh <= 1'b0;
      row <= '0; rem <= '0; col <= '0; wcnt <= '0;
      rd_valid <= 1'b0; rd_data <= 8'h00; rd_last <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      case (st)
        S_IDLE: if (start && page_count != '0) begin
          row <= start_row; rem <= page_count; kind <= K_OPEN;
          idx <= 3'd0; ph <= 1'b0; st <= S_SEND;
        end
        S_SEND: begin
          ph <= !ph;
          if (ph) begin
            if (idx == last_idx) begin
              st <= S_WAIT; wcnt <= WB_W'(T_WB); idx <= 3'd0;
            end else idx <= idx + 3'd1;
          end
        end
        S_WAIT: begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else if (rb_n) begin
            if (kind == K_OPEN) begin fresh <= 1'b1; st <= S_DEC; end
            else begin st <= S_READ; col <= '0; ph <= 1'b0; end
          end
        end
        S_DEC: begin
          ph <= 1'b0; idx <= 3'd0;
          if (can31) begin kind <= K_CACHE; st <= S_SEND; end
          else if (fresh) begin kind <= K_DIRECT; st <= S_READ; col <= '0; end
          else begin kind <= K_LAST; st <= S_SEND; end
        end
        S_READ: begin
          ph <= !ph;
          if (!ph) begin
            rd_valid <= 1'b1; rd_data <= dq_i; rd_last <= (col == COL_END);
          end else if (col == COL_END) begin
            rem <= rem - 1'b1;
            if (kind == K_CACHE) begin
              row <= row + 24'd1; fresh <= 1'b0; st <= S_DEC;
            end else if (rem == CNT_W'(1)) st <= S_IDLE;
            else begin
              row <= row + 24'd1; kind <= K_OPEN; idx <= 3'd0; st <= S_SEND;
            end
          end else col <= col + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r3_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(dq_o) && $stable(cle) && $stable(ale)));
  a_r4_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_n |-> (we_n && re_n));
  a_r7_no_cross_cache: assert property (@(posedge clk) disable iff (!rst_n)
    (cle && !we_n && dq_o == 8'h31) |-> (!(&row[DIE_ROW_BITS-1:0]) && rem >= CNT_W'(2)));
  a_r8_page_from_col0: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && $past(st) != S_READ) |-> (col == '0));
  a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);
  a_r9_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
endmodule

// File: tb/nand_cache_stream_bench.sv
`timescale 1ns/1ps
module nand_cache_stream_bench;
  localparam int PB = 4, DB = 3, TR = 10, TCB = 3, TARR = 30;
  logic clk = 0, rst_n = 0, start = 0;
  logic [23:0] start_row = '0;
  logic [7:0] page_count = '0;
  logic busy, rd_valid, rd_last, cle, ale, we_n, re_n, dq_oe, rb_n;
  logic [7:0] rd_data, dq_o, dq_i;

  int checks = 0, fails = 0;
  int busy_cnt = 0, arr_cnt = 0, col = 0, addr_n = 0;
  logic [23:0] dreg_row = '0, cache_row = '0;
  bit dreg_ok = 0, overlap_seen = 0;
  logic prev_we = 1, prev_re = 1, l_cle = 0, l_ale = 0;
  logic [7:0] l_b = 0;
  logic [7:0] ab [0:4];
  logic [7:0] exp_data[$], got_cmds[$], exp_cmds[$];
  bit exp_last[$];
  logic [23:0] got_rows[$], exp_rows[$];

  always #2 clk = ~clk;

  nand_cache_stream #(.PAGE_BYTES(PB), .DIE_ROW_BITS(DB), .CNT_W(8), .T_WB(2)) u_nand_cache_stream (
    .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row), .page_count(page_count),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_o(dq_o), .dq_oe(dq_oe),
    .dq_i(dq_i), .rb_n(rb_n));

  function automatic logic [7:0] byte_of(logic [23:0] r, int c);
    return (r[7:0] * 8'd29) ^ r[15:8] ^ r[23:16] ^ 8'(c);
  endfunction

  assign rb_n = (busy_cnt == 0);
  assign dq_i = byte_of(cache_row, col);

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (arr_cnt > 0) arr_cnt <= arr_cnt - 1;
      if (!we_n) begin
        l_b <= dq_o; l_cle <= cle; l_ale <= ale;
        check(rb_n, "R4", "write strobe while busy", 0, 1);
      end
      if (!re_n) check(rb_n, "R4", "read strobe while busy", 0, 1);
      if (we_n && !prev_we) begin
        if (l_ale) begin
          if (addr_n < 5) ab[addr_n] <= l_b;
          addr_n <= addr_n + 1;
        end else if (l_cle) begin
          got_cmds.push_back(l_b);
          case (l_b)
            8'h00: addr_n <= 0;
            8'h30: begin
              check(addr_n == 5, "R2", "address byte count", addr_n, 5);
              check(ab[0] == 0 && ab[1] == 0, "R2", "column bytes", {ab[1], ab[0]}, 0);
              got_rows.push_back({ab[4], ab[3], ab[2]});
              dreg_row <= {ab[4], ab[3], ab[2]}; cache_row <= {ab[4], ab[3], ab[2]};
              dreg_ok <= 1; col <= 0; busy_cnt <= TR; arr_cnt <= 0;
            end
            8'h31: begin
              check(dreg_ok, "R5", "31h with empty data register", 0, 1);
              check((dreg_row >> DB) == ((dreg_row + 1) >> DB), "R7", "31h crosses die",
                    int'(dreg_row), 0);
              if (arr_cnt > 0) overlap_seen <= 1;
              cache_row <= dreg_row; dreg_row <= dreg_row + 1; col <= 0;
              busy_cnt <= (arr_cnt > 0) ? arr_cnt + TCB : TCB;
              arr_cnt <= ((arr_cnt > 0) ? arr_cnt + TCB : TCB) + TARR;
            end
            8'h3F: begin
              check(dreg_ok, "R5", "3Fh with empty data register", 0, 1);
              cache_row <= dreg_row; dreg_ok <= 0; col <= 0;
              busy_cnt <= (arr_cnt > 0) ? arr_cnt + TCB : TCB; arr_cnt <= 0;
            end
            default: check(0, "R2", "unknown command", l_b, 0);
          endcase
        end
      end
      if (re_n && !prev_re) col <= col + 1;
      if (rd_valid) begin
        if (exp_data.size() == 0) check(0, "R8", "unexpected byte", rd_data, 0);
        else begin
          logic [7:0] e; bit el;
          e = exp_data.pop_front(); el = exp_last.pop_front();
          check(rd_data == e, "R8", "data byte", rd_data, e);
          check(rd_last == el, "R8", "last flag", rd_last, el);
        end
      end
      prev_we <= we_n; prev_re <= re_n;
    end
  end

  task automatic build(logic [23:0] r0, int n);
    int k = 0;
    exp_cmds.delete(); exp_rows.delete(); exp_data.delete(); exp_last.delete();
    got_cmds.delete(); got_rows.delete();
    for (int p = 0; p < n; p++)
      for (int c = 0; c < PB; c++) begin
        exp_data.push_back(byte_of(r0 + p, c)); exp_last.push_back(c == PB - 1);
      end
    while (k < n) begin
      logic [23:0] r; int seg, room;
      r = r0 + k;
      room = (1 << DB) - int'(r % (1 << DB));
      seg = (n - k < room) ? n - k : room;
      exp_cmds.push_back(8'h00); exp_cmds.push_back(8'h30); exp_rows.push_back(r);
      if (seg > 1) begin
        for (int j = 0; j < seg - 1; j++) exp_cmds.push_back(8'h31);
        exp_cmds.push_back(8'h3F);
      end
      k += seg;
    end
  endtask

  task automatic run(string req, logic [23:0] r0, int n, bit poke);
    int w = 0;
    build(r0, n);
    @(negedge clk); start_row = r0; page_count = 8'(n); start = 1;
    @(negedge clk); start = 0;
    check(busy == 1, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (15) @(negedge clk);
      start_row = 24'h000040; page_count = 8'd9; start = 1;
      @(negedge clk); start = 0;
    end
    while (busy && w < 5000) begin @(negedge clk); w++; end
    check(w < 5000, "R9", "watchdog on busy", w, 0);
    repeat (3) @(negedge clk);
    check(got_cmds.size() == exp_cmds.size(), req, "command count", got_cmds.size(), exp_cmds.size());
    for (int i = 0; i < exp_cmds.size() && i < got_cmds.size(); i++)
      check(got_cmds[i] == exp_cmds[i], req, $sformatf("command %0d", i), got_cmds[i], exp_cmds[i]);
    check(got_rows.size() == exp_rows.size(), "R2", "open count", got_rows.size(), exp_rows.size());
    for (int i = 0; i < exp_rows.size() && i < got_rows.size(); i++)
      check(got_rows[i] == exp_rows[i], "R2", "row address", got_rows[i], exp_rows[i]);
    check(exp_data.size() == 0, "R8", "bytes missing", exp_data.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    check(0, "R9", "global watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!cle && !ale && we_n && re_n && !dq_oe, "R1", "idle pins",
          {cle, ale, we_n, re_n, dq_oe}, 5'b00110);
    check(!busy && !rd_valid, "R1", "idle host side", {busy, rd_valid}, 0);
    run("R5", 24'h000010, 3, 1);
    check(overlap_seen, "R10", "31h while array loading", overlap_seen, 1);
    run("R5", 24'h000005, 1, 0);
    run("R6", 24'h000002, 4, 0);
    run("R7", 24'h000006, 5, 0);
    run("R7", 24'h000007, 3, 0);
    run("R7", 24'h00001D, 3, 0);
    run("R2", 24'hA5C3F0, 2, 0);
    build(24'h0, 0);
    @(negedge clk); start_row = 24'h000003; page_count = 8'd0; start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    check(!busy && got_cmds.size() == 0, "R9", "zero count ignored", got_cmds.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule